// File: doc/BRIEF.md
# Byte Arithmetic/Logic Unit with Condition Flags

This block combines two operand bytes into one result byte and produces six condition flags: carry, parity, half carry, zero, sign and overflow. Eight operations are available: add, add with carry, subtract, subtract with borrow, bitwise AND, OR, XOR, and compare. The operation type decides how carry, half carry and overflow are formed. An add reports carry-out. A subtract reports a borrow, which is the inverted carry. The logic operations force their arithmetic flags to zero.

The datapath has no registers. Its result and flags settle in the same cycle as the operands. Compare produces the subtract flags and holds its result-write strobe low, so the surrounding datapath keeps its destination unchanged. When the parameter for it is set, a flags register with its own write enable holds the last flags captured, and a sequencer can read them in later cycles.

Top module: `alu8_status_unit`

## Requirements
- R1: With `op_sel` = 0 (add), `result` is `op_a + op_b` modulo 256. With `op_sel` = 1 (add with carry), `carry_in` is added as well. Flag bit 0 (carry) is set when the true sum exceeds 255.
- R2: With `op_sel` = 2 (subtract), `result` is `op_a - op_b` modulo 256. With `op_sel` = 3 (subtract with borrow), `carry_in` is also subtracted. Flag bit 0 is set as a borrow when `op_b` (plus `carry_in` for op 3) exceeds `op_a`.
- R3: For the four arithmetic operations and compare, flag bit 5 (overflow) is set when the signed two's-complement result falls outside -128..127.
- R4: Flag bit 2 (half carry) is set on a carry out of bit 3 for adds, or a borrow into bit 3 for subtracts and compare. It is 0 for the logic operations.
- R5: Flag bit 3 (zero) is set exactly when `result` is 0x00.
- R6: Flag bit 4 (sign) equals bit 7 of `result`.
- R7: Flag bit 1 (parity) is 1 when `result` holds an even number of one bits and 0 when the count is odd.
- R8: With `op_sel` = 4, 5 and 6, `result` is AND, OR and XOR of the operands respectively. Carry, overflow and half carry are 0, and `carry_in` has no effect.
- R9: With `op_sel` = 7 (compare), `flags` equal those of a subtract of the same operands without `carry_in`, and `result_we` is 0. For every other operation `result_we` is 1.
- R10: `flags_q` is all zeros after reset. It loads `flags` on a rising clock edge when `flags_we` is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flags register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags register |
| op_a | input | 8 | First operand (minuend for subtract) |
| op_b | input | 8 | Second operand (subtrahend for subtract) |
| carry_in | input | 1 | Incoming carry or borrow, used by ops 1 and 3 |
| op_sel | input | 3 | Operation select |
| result | output | 8 | Result byte |
| result_we | output | 1 | Strobe that permits writing the result |
| flags | output | 6 | Combinational flags {overflow, sign, zero, half, parity, carry} |
| flags_we | input | 1 | Write enable of the flags register |
| flags_q | output | 6 | Registered flags |

## Verification
Several flags can be raised by a single operation. In an add such as 0x70 + 0x10, sign and overflow are set together. In a subtract such as 0x80 - 0x01, overflow and half carry come from the same borrow chain. The bench drives these operand pairs and checks each flag bit in the same cycle against an integer model built from the requirements. The datapath and the flags register can also act in the same cycle: new operands are applied while the register is being written, and the bench checks after the edge that the register holds the flags of the operands that were present at that edge, not those of the operands that follow.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_ADC = 3'd1,
      OP_SUB = 3'd2,
      OP_SBC = 3'd3,
      OP_AND = 3'd4,
      OP_OR  = 3'd5,
      OP_XOR = 3'd6,
      OP_CMP = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic ovf;
      logic sign;
      logic zero;
      logic half;
      logic parity;
      logic carry;
   } alu_flags_t;

   localparam int FLAG_COUNT = 6;

   function automatic logic op_is_logic(alu_op_e op);
      return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
   endfunction

   function automatic logic op_is_subtract(alu_op_e op);
      return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
   endfunction

   function automatic logic op_uses_carry(alu_op_e op);
      return (op == OP_ADC) || (op == OP_SBC);
   endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int WIDTH    = 8,
   parameter int AUX_BITS = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   input  logic             subtract,
   output logic [WIDTH-1:0] sum,
   output logic             carry_flag,
   output logic             half_flag,
   output logic             ovf_flag
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0]  b_eff;
   logic              c0;
   logic [WIDTH:0]    full_sum;
   logic [AUX_BITS:0] low_sum;

   // subtraction as a + ~b + ~borrow, then carry-out inverted into a borrow
   always_comb begin
      b_eff    = subtract ? ~b : b;
      c0       = subtract ? ~cin : cin;
      full_sum = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c0};
      low_sum  = {1'b0, a[AUX_BITS-1:0]} + {1'b0, b_eff[AUX_BITS-1:0]}
               + {{AUX_BITS{1'b0}}, c0};
      sum        = full_sum[WIDTH-1:0];
      carry_flag = full_sum[WIDTH] ^ subtract;
      half_flag  = low_sum[AUX_BITS] ^ subtract;
   end

   // signed overflow: operand sign pattern versus result sign
   generate
      if (WIDTH > 1) begin : g_ovf
         always_comb begin
            if (subtract)
               ovf_flag = (a[MSB] != b[MSB]) && (sum[MSB] != a[MSB]);
            else
               ovf_flag = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
         end
      end else begin : g_ovf_bit
         assign ovf_flag = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [1:0]       func,
   output logic [WIDTH-1:0] res
);
   // func: 0 AND, 1 OR, 2 XOR, 3 unused (AND)
   always_comb begin
      unique case (func)
         2'd1:    res = a | b;
         2'd2:    res = a ^ b;
         default: res = a & b;
      endcase
   end

endmodule

// File: rtl/alu8_flag_gen.sv
module alu8_flag_gen #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] value,
   output logic             zero,
   output logic             sign,
   output logic             parity_even
);
   logic [WIDTH-1:0] xor_chain;

   // ripple XOR chain built bit by bit
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_par
         if (i == 0) begin : g_first
            assign xor_chain[i] = value[i];
         end else begin : g_next
            assign xor_chain[i] = xor_chain[i-1] ^ value[i];
         end
      end
   endgenerate

   assign parity_even = ~xor_chain[WIDTH-1];
   assign zero        = (value == '0);
   assign sign        = value[WIDTH-1];

endmodule

// File: rtl/alu8_status_unit.sv
module alu8_status_unit
   import alu8_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter int AUX_BITS  = 4,
   parameter bit REG_FLAGS = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [WIDTH-1:0]      op_a,
   input  logic [WIDTH-1:0]      op_b,
   input  logic                  carry_in,
   input  logic [2:0]            op_sel,
   output logic [WIDTH-1:0]      result,
   output logic                  result_we,
   output logic [FLAG_COUNT-1:0] flags,
   input  logic                  flags_we,
   output logic [FLAG_COUNT-1:0] flags_q
);
   localparam int MSB = WIDTH - 1;

   // elaboration-time parameter checks
   generate
      if (WIDTH < 2) begin : g_chk_width
         $error("WIDTH must be at least 2");
      end
      if (AUX_BITS < 1 || AUX_BITS >= WIDTH) begin : g_chk_aux
         $error("AUX_BITS must lie in 1..WIDTH-1");
      end
   endgenerate

   alu_op_e    op;
   logic       is_logic, is_sub, cin_eff;
   logic [WIDTH-1:0] arith_sum, logic_res;
   logic       arith_carry, arith_half, arith_ovf;
   logic       f_zero, f_sign, f_par;
   alu_flags_t flag_s;

   assign op       = alu_op_e'(op_sel);
   assign is_logic = op_is_logic(op);
   assign is_sub   = op_is_subtract(op);
   assign cin_eff  = op_uses_carry(op) & carry_in;

   alu8_addsub #(.WIDTH(WIDTH), .AUX_BITS(AUX_BITS)) u_addsub (
      .a          (op_a),
      .b          (op_b),
      .cin        (cin_eff),
      .subtract   (is_sub),
      .sum        (arith_sum),
      .carry_flag (arith_carry),
      .half_flag  (arith_half),
      .ovf_flag   (arith_ovf)
   );

   alu8_logic_unit #(.WIDTH(WIDTH)) u_logic (
      .a    (op_a),
      .b    (op_b),
      .func (op_sel[1:0]),
      .res  (logic_res)
   );

   assign result    = is_logic ? logic_res : arith_sum;
   assign result_we = (op != OP_CMP);

   alu8_flag_gen #(.WIDTH(WIDTH)) u_flag_gen (
      .value       (result),
      .zero        (f_zero),
      .sign        (f_sign),
      .parity_even (f_par)
   );

   always_comb begin
      flag_s.carry  = is_logic ? 1'b0 : arith_carry;
      flag_s.half   = is_logic ? 1'b0 : arith_half;
      flag_s.ovf    = is_logic ? 1'b0 : arith_ovf;
      flag_s.zero   = f_zero;
      flag_s.sign   = f_sign;
      flag_s.parity = f_par;
   end

   assign flags = flag_s;

   // optional flags register
   generate
      if (REG_FLAGS) begin : g_flag_reg
         logic [FLAG_COUNT-1:0] flags_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flags_r <= '0;
            else if (flags_we)
               flags_r <= flags;
         end

         assign flags_q = flags_r;

         assert_flag_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
            flags_we |=> (flags_q == $past(flags)))
            else $error("flags register missed a load");

         assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !flags_we |=> $stable(flags_q))
            else $error("flags register changed without enable");
      end else begin : g_flag_wire
         assign flags_q = flags;
      end
   endgenerate

   assert_add_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd0) |-> (flags[0] == (result < op_a)))
      else $error("add carry disagrees with wraparound");

   assert_sub_borrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd2) |-> (flags[0] == (op_b > op_a)))
      else $error("subtract borrow disagrees with magnitude");

   assert_logic_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel >= 3'd4 && op_sel <= 3'd6) |-> (flags[0] == 1'b0 && flags[5] == 1'b0 && flags[2] == 1'b0))
      else $error("logic op left an arithmetic flag set");

   assert_cmp_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd7) |-> !result_we)
      else $error("compare raised the write strobe");

   assert_sign_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flags[4] == result[MSB])
      else $error("sign flag does not follow result MSB");

endmodule

// File: tb/alu8_status_unit_tb.sv
module alu8_status_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 24;

   // {op[2:0], a[7:0], b[7:0], cin}
   localparam logic [19:0] VEC [NVEC] = '{
      {3'd0, 8'd1,   8'd5,   1'b0}, {3'd0, 8'd255, 8'd7,   1'b1},
      {3'd0, 8'd200, 8'd100, 1'b0}, {3'd0, 8'h08,  8'h08,  1'b0},
      {3'd1, 8'hFF,  8'h00,  1'b1}, {3'd1, 8'h7F,  8'h00,  1'b1},
      {3'd1, 8'h12,  8'h34,  1'b0}, {3'd2, 8'd1,   8'd5,   1'b1},
      {3'd2, 8'd200, 8'd100, 1'b0}, {3'd2, 8'd100, 8'd56,  1'b0},
      {3'd2, 8'h80,  8'h01,  1'b0}, {3'd3, 8'h00,  8'h00,  1'b1},
      {3'd3, 8'h50,  8'h20,  1'b1}, {3'd3, 8'h80,  8'h7F,  1'b0},
      {3'd4, 8'hF0,  8'h3C,  1'b1}, {3'd4, 8'h55,  8'hAA,  1'b0},
      {3'd5, 8'h80,  8'h01,  1'b1}, {3'd5, 8'h00,  8'h00,  1'b0},
      {3'd6, 8'hA5,  8'hA5,  1'b0}, {3'd6, 8'h0F,  8'h01,  1'b1},
      {3'd7, 8'd3,   8'd5,   1'b1}, {3'd7, 8'h42,  8'h42,  1'b0},
      {3'd7, 8'h7F,  8'hFF,  1'b0}, {3'd0, 8'h70,  8'h10,  1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] op_a = '0, op_b = '0;
   logic       carry_in = 1'b0;
   logic [2:0] op_sel = '0;
   logic       flags_we = 1'b0;
   logic [7:0] result;
   logic       result_we;
   logic [5:0] flags, flags_q;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu8_status_unit u_dut (
      .clk (clk), .rst_n (rst_n), .op_a (op_a), .op_b (op_b),
      .carry_in (carry_in), .op_sel (op_sel), .result (result),
      .result_we (result_we), .flags (flags), .flags_we (flags_we),
      .flags_q (flags_q)
   );

   // integer model from the requirements: returns {we, result, flags}
   function automatic logic [14:0] model(logic [2:0] op, logic [7:0] a, logic [7:0] b, logic ci);
      int ai = a, bi = b, sa, sb, t, s, c, lo;
      logic [7:0] r;
      logic cy = 0, hf = 0, ov = 0;
      sa = (ai > 127) ? ai - 256 : ai;
      sb = (bi > 127) ? bi - 256 : bi;
      if (op <= 3'd1) begin
         c = (op == 3'd1) ? int'(ci) : 0;
         t = ai + bi + c; s = sa + sb + c; lo = ai % 16 + bi % 16 + c;
         cy = (t > 255); hf = (lo > 15); ov = (s > 127 || s < -128);
         r = t[7:0];
      end else if (op <= 3'd3 || op == 3'd7) begin
         c = (op == 3'd3) ? int'(ci) : 0;
         t = ai - bi - c; s = sa - sb - c; lo = ai % 16 - bi % 16 - c;
         cy = (t < 0); hf = (lo < 0); ov = (s > 127 || s < -128);
         r = t[7:0];
      end else if (op == 3'd4) r = a & b;
      else if (op == 3'd5) r = a | b;
      else r = a ^ b;
      return {op != 3'd7, r, ov, r[7], r == 8'd0, hf, ~^r, cy};
   endfunction

   function automatic string tag_of(logic [2:0] op);
      case (op)
         3'd0, 3'd1: return "R1/R3/R4/R5/R6/R7";
         3'd2, 3'd3: return "R2/R3/R4/R5/R6/R7";
         3'd7:       return "R9";
         default:    return "R8";
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(logic [2:0] op, logic [7:0] a, logic [7:0] b, logic ci);
      @(negedge clk);
      op_sel = op; op_a = a; op_b = b; carry_in = ci;
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      logic [14:0] exp;
      repeat (3) @(negedge clk);
      check("R10 reset", 32'(flags_q), 32'd0);
      rst_n = 1'b1;

      // table walk against the model
      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][19:17], VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
         exp = model(VEC[i][19:17], VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
         check(tag_of(VEC[i][19:17]), 32'({result_we, result, flags}), 32'(exp));
      end

      // directed corner cases; flags {ovf,sign,zero,half,par,carry}
      apply(3'd0, 8'd255, 8'd7, 1'b0);
      check("R1 255+7 result", 32'(result), 32'd6);
      check("R1 255+7 carry", 32'(flags[0]), 32'd1);
      apply(3'd0, 8'd1, 8'd5, 1'b0);
      check("R1 1+5 carry", 32'({result, flags[0]}), 32'({8'd6, 1'b0}));
      apply(3'd1, 8'h0F, 8'h00, 1'b1);
      check("R4 adc half carry", 32'({result, flags[2]}), 32'({8'h10, 1'b1}));
      apply(3'd2, 8'd1, 8'd5, 1'b0);
      check("R2 1-5 borrow", 32'({result, flags[0]}), 32'({8'd252, 1'b1}));
      apply(3'd2, 8'd200, 8'd100, 1'b0);
      check("R2 200-100", 32'({result, flags[0]}), 32'({8'd100, 1'b0}));
      apply(3'd3, 8'd5, 8'd5, 1'b1);
      check("R2 sbc borrow", 32'({result, flags[0]}), 32'({8'hFF, 1'b1}));
      apply(3'd0, 8'd100, 8'd50, 1'b0);
      check("R3 100+50 overflow", 32'(flags[5]), 32'd1);
      apply(3'd2, 8'h80, 8'h01, 1'b0);
      check("R3 R4 0x80-1", 32'({result, flags[5], flags[2]}), 32'({8'h7F, 1'b1, 1'b1}));
      apply(3'd2, 8'd7, 8'd7, 1'b0);
      check("R5 zero", 32'(flags[3]), 32'd1);
      apply(3'd0, 8'h70, 8'h10, 1'b0);
      check("R6 sign with overflow", 32'({flags[5], flags[4]}), 32'({1'b1, 1'b1}));
      apply(3'd6, 8'h03, 8'h00, 1'b0);
      check("R7 parity even", 32'(flags[1]), 32'd1);
      apply(3'd5, 8'h01, 8'h00, 1'b0);
      check("R7 parity odd", 32'(flags[1]), 32'd0);
      apply(3'd4, 8'hFF, 8'hFF, 1'b1);
      check("R8 and ignores carry_in", 32'({result, flags}), 32'({8'hFF, 6'b010010}));
      apply(3'd7, 8'd3, 8'd5, 1'b1);
      check("R9 compare", 32'({result_we, flags[0]}), 32'({1'b0, 1'b1}));
      apply(3'd0, 8'd3, 8'd5, 1'b0);
      check("R9 add writes", 32'(result_we), 32'd1);

      // flags register: load, then operands change together with the edge
      apply(3'd2, 8'd1, 8'd5, 1'b0);
      flags_we = 1'b1;
      exp = model(3'd2, 8'd1, 8'd5, 1'b0);
      @(negedge clk);
      op_sel = 3'd6; op_a = 8'h00; op_b = 8'h00;
      flags_we = 1'b0;
      #1;
      check("R10 load", 32'(flags_q), 32'(exp[5:0]));
      @(negedge clk); #1;
      check("R10 hold", 32'(flags_q), 32'(exp[5:0]));
      flags_we = 1'b1;
      @(negedge clk); #1;
      flags_we = 1'b0;
      check("R10 reload", 32'(flags_q), 32'(6'b001010));

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule